// File: doc/BRIEF.md
# Indexed Register Host Port

This block is the host-facing access port of a display controller. A host on a 16-bit parallel bus uses one select line to mark each cycle. A command cycle loads an 8-bit register index. Each data cycle after it reads or writes the register at that index. After the access, the index moves on by itself, so the host can walk through a group of registers without sending a command for each one.

Behind the port sits a representative register file. It holds a clock divider, panel geometry fields, 10-bit positions split over two 8-bit registers, two lookup tables (gamma and filter coefficients) reached through a pointer register and a data register, a latched interrupt status, and a pixel data port. A write to the pixel data port only produces a strobe with the written word. The value a register stores is not always the value written: masks are applied, split fields are merged, and the divider is kept offset by one.

Each host access is one clock cycle, qualified by `host_valid`. Read data, the pixel strobe and the error flag are registered and appear in the cycle after the access.

Top module: `regport_host`

## Requirements
- R1: A cycle with `host_valid`=1 and `host_dc`=0 loads `host_wdata[7:0]` as the index, and upper bus bits are ignored. The index is 0 after reset and holds on idle cycles.
- R2: A data write (`host_dc`=1, `host_we`=1) advances the index by 2, modulo 256. The index stays put when it is 0x90 (pixel port), 0x5a (filter data) or 0xb8 (gamma data).
- R3: A data read (`host_dc`=1, `host_we`=0) advances the index by 1. `rd_valid` is high for the one cycle after the read, and `rd_data` then carries the register value, zero-extended.
- R4: Writing 0xb6 sets an 8-bit gamma pointer, and reading 0xb6 returns it. Each read or write at 0xb8 accesses entry [pointer] of a 256×8 table and then increments the pointer, which wraps from 255 to 0.
- R5: Writing 0x58 sets the filter pointer to value[4:0], and reading 0x58 returns the pointer. Each access at 0x5a uses entry [pointer] of a 32×8 table and then increments the pointer. Once the pointer is 32, writes are ignored, reads return 0 and the pointer stays at 32.
- R6: Writing 0x04 stores value[5:0]+1 as the divider. Reading 0x04 returns (divider−1) with bit 7 set. The divider is 9 after reset, so the first read gives 0x88.
- R7: Height (0x2e low, 0x30 high) and output-window X start (0x7c low, 0x7e high) are 10-bit fields. A write to the low register sets bits 7:0. A write to the high register sets bits 9:8 from value bits 1:0. Each write keeps the other half. A read of the high register returns bits 9:8 in bits 1:0.
- R8: Register 0x2a holds the panel width divided by 8 as an 8-bit value (value[7:0]) and reads back the same. It reads 1 after reset.
- R9: A write at 0x90 gives `pix_stb` high for the next cycle, with `pix_data` equal to the written word. A read at 0x90 returns 0.
- R10: Each bit set on `irq_set` sets the matching bit of the status at 0xf6. A write to 0xf6 ANDs the value into the status. When a set and a write land in the same cycle, the set wins.
- R11: 0x00 reads 0xa5 and 0x02 reads 0x83, and writes to them change nothing. 0xe8 stores value & 0x1b and always reads back with bit 5 set.
- R12: After reset, 0x28 reads 0x74, the height reads 1, 0xf8 reads 0xff, and both table pointers read 0.
- R13: A data access to an index outside the register set reads 0 and writes nothing. It raises `idx_err` for the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | A host access happens this cycle |
| host_dc | input | 1 | 0 = index load, 1 = data access |
| host_we | input | 1 | 1 = data write, 0 = data read (when host_dc=1) |
| host_wdata | input | 16 | Index or write value |
| irq_set | input | 8 | Interrupt events that set status bits |
| rd_valid | output | 1 | rd_data is valid this cycle |
| rd_data | output | 16 | Read result |
| pix_stb | output | 1 | Pixel port written in the previous cycle |
| pix_data | output | 16 | Word written to the pixel port |
| idx_err | output | 1 | Previous access used an unknown index |

## Verification
The bench first targets the split between the two index steps. If the streaming ports advanced like ordinary registers, a second word to the pixel port would land at 0x92, which shows up as a missing strobe and an error flag. It then pushes the gamma pointer across 255→0 and the filter pointer up to 32. A wrapping filter pointer would overwrite entry 0 and return stale data where 0 is expected, and a gamma pointer without a wrap would lose the written entries. It also writes only one half of each split field, issues an index command with upper bus bits set, and lands an interrupt set and a clear in the same cycle. A design with the wrong mask, shift or priority returns a read value that differs from the model.

// File: rtl/rp_pkg.sv
package rp_pkg;

    localparam int HOST_W = 16;
    localparam int IDX_W  = 8;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [HOST_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_INDEX,
        OP_WRITE,
        OP_READ
    } host_op_e;

    typedef struct packed {
        host_op_e op;
        word_t    val;
    } host_acc_t;

    localparam idx_t IX_REV    = 8'h00;
    localparam idx_t IX_CFG    = 8'h02;
    localparam idx_t IX_PLL    = 8'h04;
    localparam idx_t IX_LCD    = 8'h28;
    localparam idx_t IX_HDIV   = 8'h2a;
    localparam idx_t IX_HGT_LO = 8'h2e;
    localparam idx_t IX_HGT_HI = 8'h30;
    localparam idx_t IX_FPTR   = 8'h58;
    localparam idx_t IX_FDAT   = 8'h5a;
    localparam idx_t IX_OWX_LO = 8'h7c;
    localparam idx_t IX_OWX_HI = 8'h7e;
    localparam idx_t IX_PIX    = 8'h90;
    localparam idx_t IX_GPTR   = 8'hb6;
    localparam idx_t IX_GDAT   = 8'hb8;
    localparam idx_t IX_NDS    = 8'he8;
    localparam idx_t IX_IRQ    = 8'hf6;
    localparam idx_t IX_PDN    = 8'hf8;

    localparam word_t REV_CODE  = 16'h00a5;
    localparam word_t CFG_CODE  = 16'h0083;
    localparam logic [7:0] NDS_MASK  = 8'h1b;
    localparam logic [7:0] NDS_FIXED = 8'h20;

    function automatic logic idx_streams(idx_t i);
        return (i == IX_PIX) || (i == IX_FDAT) || (i == IX_GDAT);
    endfunction

    function automatic logic idx_known(idx_t i);
        case (i)
            IX_REV, IX_CFG, IX_PLL, IX_LCD, IX_HDIV, IX_HGT_LO, IX_HGT_HI,
            IX_FPTR, IX_FDAT, IX_OWX_LO, IX_OWX_HI, IX_PIX, IX_GPTR,
            IX_GDAT, IX_NDS, IX_IRQ, IX_PDN: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [9:0] put_low(logic [9:0] cur, word_t v);
        return {cur[9:8], v[7:0]};
    endfunction

    function automatic logic [9:0] put_high(logic [9:0] cur, word_t v);
        return {v[1:0], cur[7:0]};
    endfunction

endpackage

// File: rtl/rp_index.sv
module rp_index
    import rp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_acc_t acc,
    output idx_t      idx
);
    localparam idx_t WR_STEP = idx_t'(2);
    localparam idx_t RD_STEP = idx_t'(1);

    idx_t idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else begin
            case (acc.op)
                OP_INDEX: idx_q <= acc.val[IDX_W-1:0];
                OP_WRITE: if (!idx_streams(idx_q)) idx_q <= idx_q + WR_STEP;
                OP_READ:  idx_q <= idx_q + RD_STEP;
                default:  idx_q <= idx_q;
            endcase
        end
    end

    assign idx = idx_q;
endmodule

// File: rtl/rp_ptr_table.sv
module rp_ptr_table
    import rp_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int DW       = 8,
    parameter bit SATURATE = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_ptr,
    input  word_t         set_val,
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output word_t         ptr_rd
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = SATURATE ? AW + 1 : AW;

    logic [PW-1:0] ptr_q;
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] addr;
    logic          in_range;

    assign addr = ptr_q[AW-1:0];

    generate
        if (SATURATE) begin : g_sat
            localparam logic [PW-1:0] LIMIT = PW'(DEPTH);
            assign in_range = (ptr_q < LIMIT);
        end else begin : g_wrap
            assign in_range = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (set_ptr) begin
            ptr_q <= PW'(set_val[AW-1:0]);
        end else if ((acc_rd || acc_wr) && in_range) begin
            ptr_q <= ptr_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (acc_wr && in_range) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata  = in_range ? mem[addr] : '0;
    assign ptr_rd = HOST_W'(ptr_q);
endmodule

// File: rtl/rp_regfile.sv
module rp_regfile
    import rp_pkg::*;
#(
    parameter int GAMMA_DEPTH = 256,
    parameter int FILT_DEPTH  = 32,
    parameter int IRQ_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  idx_t             idx,
    input  host_acc_t        acc,
    input  logic [IRQ_W-1:0] irq_set,
    output word_t            rd_val,
    output logic             unk,
    output logic             pix_hit
);
    localparam int TW = 8;

    logic wr, rd;
    assign wr = (acc.op == OP_WRITE);
    assign rd = (acc.op == OP_READ);

    logic [6:0]       pll_q;
    logic [7:0]       lcd_q, hdiv_q, nds_q, pdn_q;
    logic [9:0]       hgt_q, owx_q;
    logic [IRQ_W-1:0] irq_q;

    logic [TW-1:0] g_rdata, f_rdata;
    word_t         g_ptr, f_ptr;

    rp_ptr_table #(.DEPTH(GAMMA_DEPTH), .DW(TW), .SATURATE(1'b0)) u_gamma (
        .clk     (clk),
        .rst     (rst),
        .set_ptr (wr && idx == IX_GPTR),
        .set_val (acc.val),
        .acc_rd  (rd && idx == IX_GDAT),
        .acc_wr  (wr && idx == IX_GDAT),
        .wdata   (acc.val[TW-1:0]),
        .rdata   (g_rdata),
        .ptr_rd  (g_ptr)
    );

    rp_ptr_table #(.DEPTH(FILT_DEPTH), .DW(TW), .SATURATE(1'b1)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .set_ptr (wr && idx == IX_FPTR),
        .set_val (acc.val),
        .acc_rd  (rd && idx == IX_FDAT),
        .acc_wr  (wr && idx == IX_FDAT),
        .wdata   (acc.val[TW-1:0]),
        .rdata   (f_rdata),
        .ptr_rd  (f_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pll_q  <= 7'd9;
            lcd_q  <= 8'h74;
            hdiv_q <= 8'd1;
            hgt_q  <= 10'd1;
            owx_q  <= '0;
            nds_q  <= '0;
            pdn_q  <= 8'hff;
        end else if (wr) begin
            case (idx)
                IX_PLL:    pll_q  <= 7'(acc.val[5:0]) + 7'd1;
                IX_LCD:    lcd_q  <= acc.val[7:0];
                IX_HDIV:   hdiv_q <= acc.val[7:0];
                IX_HGT_LO: hgt_q  <= put_low(hgt_q, acc.val);
                IX_HGT_HI: hgt_q  <= put_high(hgt_q, acc.val);
                IX_OWX_LO: owx_q  <= put_low(owx_q, acc.val);
                IX_OWX_HI: owx_q  <= put_high(owx_q, acc.val);
                IX_NDS:    nds_q  <= acc.val[7:0] & NDS_MASK;
                IX_PDN:    pdn_q  <= acc.val[7:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else if (wr && idx == IX_IRQ) begin
            irq_q <= (irq_q & acc.val[IRQ_W-1:0]) | irq_set;
        end else begin
            irq_q <= irq_q | irq_set;
        end
    end

    always_comb begin
        rd_val = '0;
        case (idx)
            IX_REV:    rd_val = REV_CODE;
            IX_CFG:    rd_val = CFG_CODE;
            IX_PLL:    rd_val = {8'h00, 2'b10, 6'(pll_q - 7'd1)};
            IX_LCD:    rd_val = HOST_W'(lcd_q);
            IX_HDIV:   rd_val = HOST_W'(hdiv_q);
            IX_HGT_LO: rd_val = HOST_W'(hgt_q[7:0]);
            IX_HGT_HI: rd_val = HOST_W'(hgt_q[9:8]);
            IX_OWX_LO: rd_val = HOST_W'(owx_q[7:0]);
            IX_OWX_HI: rd_val = HOST_W'(owx_q[9:8]);
            IX_FPTR:   rd_val = f_ptr;
            IX_FDAT:   rd_val = HOST_W'(f_rdata);
            IX_GPTR:   rd_val = g_ptr;
            IX_GDAT:   rd_val = HOST_W'(g_rdata);
            IX_NDS:    rd_val = HOST_W'(nds_q | NDS_FIXED);
            IX_IRQ:    rd_val = HOST_W'(irq_q);
            IX_PDN:    rd_val = HOST_W'(pdn_q);
            default:   rd_val = '0;
        endcase
    end

    assign unk     = (wr || rd) && !idx_known(idx);
    assign pix_hit = wr && (idx == IX_PIX);
endmodule

// File: rtl/regport_host.sv
module regport_host
    import rp_pkg::*;
#(
    parameter int GAMMA_DEPTH = 256,
    parameter int FILT_DEPTH  = 32,
    parameter int IRQ_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic              host_dc,
    input  logic              host_we,
    input  logic [15:0]       host_wdata,
    input  logic [IRQ_W-1:0]  irq_set,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              pix_stb,
    output logic [15:0]       pix_data,
    output logic              idx_err
);
    host_acc_t acc;
    idx_t      cur_idx;
    word_t     rd_val;
    logic      unk, pix_hit;

    always_comb begin
        acc.val = host_wdata;
        if (!host_valid)   acc.op = OP_NONE;
        else if (!host_dc) acc.op = OP_INDEX;
        else if (host_we)  acc.op = OP_WRITE;
        else               acc.op = OP_READ;
    end

    rp_index u_index (
        .clk (clk),
        .rst (rst),
        .acc (acc),
        .idx (cur_idx)
    );

    rp_regfile #(
        .GAMMA_DEPTH (GAMMA_DEPTH),
        .FILT_DEPTH  (FILT_DEPTH),
        .IRQ_W       (IRQ_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .idx     (cur_idx),
        .acc     (acc),
        .irq_set (irq_set),
        .rd_val  (rd_val),
        .unk     (unk),
        .pix_hit (pix_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            pix_stb  <= 1'b0;
            pix_data <= '0;
            idx_err  <= 1'b0;
        end else begin
            rd_valid <= (acc.op == OP_READ);
            rd_data  <= (acc.op == OP_READ) ? rd_val : '0;
            pix_stb  <= pix_hit;
            if (pix_hit) pix_data <= acc.val;
            idx_err  <= unk;
        end
    end
endmodule

// File: rtl/regport_host_chk.sv
module regport_host_chk
    import rp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        host_valid,
    input logic        host_dc,
    input logic        host_we,
    input logic [15:0] host_wdata,
    input logic [7:0]  idx,
    input logic        rd_valid,
    input logic        pix_stb,
    input logic        idx_err
);
    logic is_wr, is_rd;
    assign is_wr = host_valid && host_dc && host_we;
    assign is_rd = host_valid && host_dc && !host_we;

    // R1
    a_r1_cmd_load: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_dc) |=> (idx == $past(host_wdata[7:0])));
    // R1
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !host_valid |=> $stable(idx));
    // R2
    a_r2_step_two: assert property (@(posedge clk) disable iff (rst)
        (is_wr && !idx_streams(idx)) |=> (idx == 8'($past(idx) + 8'd2)));
    // R2
    a_r2_stream_hold: assert property (@(posedge clk) disable iff (rst)
        (is_wr && idx_streams(idx)) |=> $stable(idx));
    // R3
    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> (idx == 8'($past(idx) + 8'd1)));
    // R3
    a_r3_rd_valid: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> rd_valid);
    // R9
    a_r9_pix_origin: assert property (@(posedge clk) disable iff (rst)
        pix_stb |-> $past(is_wr && idx == 8'h90));
    // R13
    a_r13_err_origin: assert property (@(posedge clk) disable iff (rst)
        idx_err |-> $past(host_valid && host_dc));
endmodule

bind regport_host regport_host_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_dc    (host_dc),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .idx        (cur_idx),
    .rd_valid   (rd_valid),
    .pix_stb    (pix_stb),
    .idx_err    (idx_err)
);

// File: tb/sim_regport_host.sv
`timescale 1ns/100ps
module sim_regport_host;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        host_valid = 1'b0, host_dc = 1'b0, host_we = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [7:0]  irq_set = '0;
    logic        rd_valid, pix_stb, idx_err;
    logic [15:0] rd_data, pix_data;

    regport_host u0 (
        .clk(clk), .rst(rst), .host_valid(host_valid), .host_dc(host_dc),
        .host_we(host_we), .host_wdata(host_wdata), .irq_set(irq_set),
        .rd_valid(rd_valid), .rd_data(rd_data), .pix_stb(pix_stb),
        .pix_data(pix_data), .idx_err(idx_err)
    );

    int n_chk = 0, n_fail = 0;

    // behavioural reference state
    int m_idx, m_pll, m_lcd, m_hdiv, m_hgt, m_owx, m_fptr, m_gptr, m_nds, m_irq, m_pdn;
    int m_ftab [32];
    int m_gtab [256];
    int e_rv, e_rd, e_pix, e_pd, e_err;

    function automatic void m_reset();
        m_idx = 0; m_pll = 9; m_lcd = 'h74; m_hdiv = 1; m_hgt = 1; m_owx = 0;
        m_fptr = 0; m_gptr = 0; m_nds = 0; m_irq = 0; m_pdn = 'hff;
    endfunction

    function automatic int m_read(int i);
        int r;
        r = 0;
        case (i)
            'h00: r = 'ha5;
            'h02: r = 'h83;
            'h04: r = ((m_pll - 1) & 'h3f) | 'h80;
            'h28: r = m_lcd;
            'h2a: r = m_hdiv;
            'h2e: r = m_hgt % 256;
            'h30: r = m_hgt / 256;
            'h7c: r = m_owx % 256;
            'h7e: r = m_owx / 256;
            'h58: r = m_fptr;
            'h5a: if (m_fptr < 32) begin r = m_ftab[m_fptr]; m_fptr++; end
            'h90: r = 0;
            'hb6: r = m_gptr;
            'hb8: begin r = m_gtab[m_gptr]; m_gptr = (m_gptr + 1) % 256; end
            'he8: r = m_nds | 'h20;
            'hf6: r = m_irq;
            'hf8: r = m_pdn;
            default: e_err = 1;
        endcase
        return r;
    endfunction

    function automatic void m_write(int i, int v);
        case (i)
            'h00, 'h02: ;
            'h04: m_pll = (v & 'h3f) + 1;
            'h28: m_lcd = v & 'hff;
            'h2a: m_hdiv = v & 'hff;
            'h2e: m_hgt = (m_hgt & 'h300) | (v & 'hff);
            'h30: m_hgt = (m_hgt & 'hff) | ((v & 3) * 256);
            'h7c: m_owx = (m_owx & 'h300) | (v & 'hff);
            'h7e: m_owx = (m_owx & 'hff) | ((v & 3) * 256);
            'h58: m_fptr = v & 'h1f;
            'h5a: if (m_fptr < 32) begin m_ftab[m_fptr] = v & 'hff; m_fptr++; end
            'h90: begin e_pix = 1; e_pd = v & 'hffff; end
            'hb6: m_gptr = v & 'hff;
            'hb8: begin m_gtab[m_gptr] = v & 'hff; m_gptr = (m_gptr + 1) % 256; end
            'he8: m_nds = v & 'h1b;
            'hf6: m_irq = m_irq & v & 'hff;
            'hf8: m_pdn = v & 'hff;
            default: e_err = 1;
        endcase
    endfunction

    function automatic void m_step(bit v, bit dc, bit we, int val, int set);
        e_rv = 0; e_rd = 0; e_pix = 0; e_pd = 0; e_err = 0;
        if (v) begin
            if (!dc) m_idx = val & 'hff;
            else if (we) begin
                m_write(m_idx, val);
                if (m_idx != 'h90 && m_idx != 'h5a && m_idx != 'hb8)
                    m_idx = (m_idx + 2) % 256;
            end else begin
                e_rv = 1;
                e_rd = m_read(m_idx);
                m_idx = (m_idx + 1) % 256;
            end
        end
        m_irq = m_irq | (set & 'hff);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(bit v, bit dc, bit we, int val, int set, string tag);
        @(negedge clk);
        host_valid = v; host_dc = dc; host_we = we;
        host_wdata = 16'(val); irq_set = 8'(set);
        @(posedge clk);
        m_step(v, dc, we, val, set);
        #1;
        check(tag, 32'(rd_valid), 32'(e_rv), "rd_valid");
        if (e_rv != 0) check(tag, 32'(rd_data), 32'(e_rd), "rd_data");
        check(tag, 32'(pix_stb), 32'(e_pix), "pix_stb");
        if (e_pix != 0) check(tag, 32'(pix_data), 32'(e_pd), "pix_data");
        check(tag, 32'(idx_err), 32'(e_err), "idx_err");
    endtask

    task automatic cmd(int i, string tag); step(1, 0, 0, i, 0, tag); endtask
    task automatic wr(int v, string tag);  step(1, 1, 1, v, 0, tag); endtask
    task automatic rd(string tag);         step(1, 1, 0, 0, 0, tag); endtask
    task automatic idle(string tag);       step(0, 0, 0, 0, 0, tag); endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        idle("R12 reset idle");

        // R12 reset values and R11 constants
        cmd('h28, "R12"); rd("R12 lcd reset");
        cmd('h2e, "R12"); rd("R12 height low reset");
        cmd('hf8, "R12"); rd("R12 pulldown reset");
        cmd('hb6, "R12"); rd("R12 gamma ptr reset");
        cmd('h58, "R12"); rd("R12 filter ptr reset");
        cmd('h00, "R11"); rd("R11 revision");
        rd("R13 unknown after read step");
        rd("R11 config via R3 read step");
        cmd('h02, "R11"); wr('h1234, "R11 ro write"); cmd('h02, "R11"); rd("R11 config kept");

        // R6 divider
        cmd('h04, "R6"); rd("R6 reset divider");
        cmd('h04, "R6"); wr('hff, "R6 write"); cmd('h04, "R6"); rd("R6 readback");
        cmd('h04, "R6"); wr('h05, "R6 write small"); cmd('h04, "R6"); rd("R6 readback small");

        // R1 upper bits ignored, R2 step and wrap, R8
        cmd('h3f2a, "R1 upper bits"); wr('h5a5, "R8 width");
        wr('h77, "R13 write at 2c");
        cmd('h2a, "R8"); rd("R8 width readback");
        cmd('hfe, "R2"); wr('h11, "R13 write at fe"); wr('h99, "R2 wrap to 00");
        rd("R2 idx now 02");
        idle("R1 idle");

        // R7 split fields
        cmd('h2e, "R7"); wr('h1c4, "R7 low"); wr('h0306, "R7 high");
        cmd('h2e, "R7"); rd("R7 height low"); cmd('h30, "R7"); rd("R7 height high");
        cmd('h30, "R7"); wr('h01, "R7 high only"); cmd('h2e, "R7"); rd("R7 low kept");
        cmd('h7c, "R7"); wr('hab, "R7 owx low"); wr('h02, "R7 owx high");
        cmd('h7c, "R7"); wr('h10, "R7 owx low again");
        cmd('h7e, "R7"); rd("R7 owx high kept"); cmd('h7c, "R7"); rd("R7 owx low");

        // R4 gamma wrap
        cmd('hb6, "R4"); wr('hfe, "R4 set ptr");
        wr('h11, "R4 data fe"); wr('h22, "R4 data ff"); wr('h133, "R4 data 00 wrap");
        cmd('hb6, "R4"); rd("R4 ptr after wrap");
        cmd('hb6, "R4"); wr('hfe, "R4 reset ptr");
        for (int k = 0; k < 3; k++) begin
            cmd('hb8, "R4"); rd("R4 gamma read");
        end
        cmd('hb6, "R4"); wr('h40, "R4 ptr 40");
        for (int k = 0; k < 6; k++) wr(k * 37 + 5, "R4 fill");
        cmd('hb6, "R4"); wr('h40, "R4 ptr 40");
        for (int k = 0; k < 6; k++) begin
            cmd('hb8, "R4"); rd("R4 fill read");
        end

        // R5 filter saturation
        cmd('h58, "R5"); wr('h3e, "R5 ptr masked to 1e");
        wr('h0a, "R5 e1e"); wr('h0b, "R5 e1f"); wr('h0c, "R5 ignored");
        cmd('h58, "R5"); rd("R5 ptr at 32");
        cmd('h5a, "R5"); rd("R5 read beyond");
        cmd('h58, "R5"); rd("R5 ptr held");
        cmd('h58, "R5"); wr('h1e, "R5 ptr 1e");
        cmd('h5a, "R5"); rd("R5 read e1e"); cmd('h5a, "R5"); rd("R5 read e1f");
        cmd('h58, "R5"); wr('h00, "R5 ptr 0"); wr('h44, "R5 e0");
        cmd('h58, "R5"); wr('h00, "R5 ptr 0"); cmd('h5a, "R5"); rd("R5 read e0");

        // R9 pixel port
        cmd('h1290, "R9"); wr('h1234, "R9 pix 1"); wr('habcd, "R9 pix 2");
        idle("R9 no strobe"); rd("R9 read zero");

        // R10 interrupt status
        step(0, 0, 0, 0, 'h0f, "R10 set");
        cmd('hf6, "R10"); wr('h05, "R10 and");
        cmd('hf6, "R10"); rd("R10 after and");
        cmd('hf6, "R10"); step(1, 1, 1, 'h00, 'h80, "R10 set beats clear");
        cmd('hf6, "R10"); rd("R10 set priority");

        // R11 non-display status
        cmd('he8, "R11"); wr('hff, "R11 nds write"); cmd('he8, "R11"); rd("R11 nds read");
        cmd('he8, "R11"); wr('h00, "R11 nds clear"); cmd('he8, "R11"); rd("R11 nds fixed bit");

        // R13 unknown index
        cmd('h11, "R13"); wr('h55, "R13 unknown write"); cmd('h11, "R13"); rd("R13 unknown read");
        idle("R13 flag drops");
        cmd('hf8, "R13"); rd("R13 pulldown untouched");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule